// File: doc/BRIEF.md
# Per-Port Pin Function Multiplexer

This block connects each pin of one I/O port to one internal source. A 32-bit select register holds a 4-bit code per pin, and the code picks what drives the pad. The choices are a firmware data register, one of four analog connection modes, one of four pin-specific active-mode peripherals, or one of two pin-specific sources that keep running in deep sleep. For each pin the block produces an output value, an output enable, an analog-connect control and an input-buffer enable. The pad input is routed back only to the source that is currently selected.

After power-up every ordinary pin sits in a high-impedance analog state with its input buffer off until software writes its select field. Pins wired to the debug port come out of reset already set to the debug source. In deep sleep the block latches each pin's output value and output enable and holds them. Pins whose code names a deep-sleep source keep following that source, and select writes are refused for the whole deep-sleep period.

Top module: `pin_route_mux`

## Requirements
- R1: Pin p uses select bits [4p+3:4p]. When `wr_en` is high at a clock edge, each byte lane b with `wr_be[b]` set stores `wr_data[8b+7:8b]`. `rd_data` always shows the stored register, every code included, exactly as written.
- R2: After reset, pins in `DBG_PINS` read code 15 and all other pins read code 0. A pin outside `DBG_PINS` stays unconfigured until the byte lane that holds its field is written. While unconfigured it has `pin_oe`=0, `pin_out`=0, `pin_ana`=1 and `pin_ibe`=0.
- R3: Code 0 drives `pin_out` from `gpio_dout[p]` and `pin_oe` from `gpio_doe[p]`, with `pin_ana`=0.
- R4: Codes 4, 5, 6 and 7 (analog sense, shield, bus A, bus B) give `pin_oe`=0, `pin_out`=0 and `pin_ana`=1.
- R5: Code 8+k (k=0..3) drives `pin_out` and `pin_oe` from `act_out[4p+k]` and `act_oe[4p+k]`, with `pin_ana`=0.
- R6: Code 14+k (k=0 serial bus, k=1 debug) drives `pin_out` and `pin_oe` from `ds_out[2p+k]` and `ds_oe[2p+k]`, with `pin_ana`=0. This holds in deep sleep as well.
- R7: Codes 1, 2, 3, 12 and 13 give `pin_out`=0, `pin_oe`=0 and `pin_ana`=0.
- R8: For a configured pin, `gpio_din[p]` equals `pad_in[p]`. `act_in[4p+k]` and `ds_in[2p+k]` equal `pad_in[p]` only while the code selects that source, and are 0 otherwise. For an unconfigured pin all of these inputs are 0.
- R9: At the first clock edge where `ds_req` is high, each pin's `pin_out` and `pin_oe` are captured. Pins with codes below 14 then show the captured values until the first edge where `ds_req` is low again.
- R10: A write presented while `ds_req` is high changes no stored bit.
- R11: `pin_ibe` stays 1 for every configured pin during deep sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_be | input | 4 | Byte lane strobes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Stored select register |
| gpio_dout | input | 8 | Firmware data register value per pin |
| gpio_doe | input | 8 | Firmware drive enable per pin |
| gpio_din | output | 8 | Pad input to firmware |
| act_out | input | 32 | Active-source outputs, 4 per pin |
| act_oe | input | 32 | Active-source output enables |
| act_in | output | 32 | Pad input to active sources |
| ds_out | input | 16 | Deep-sleep-source outputs, 2 per pin |
| ds_oe | input | 16 | Deep-sleep-source output enables |
| ds_in | output | 16 | Pad input to deep-sleep sources |
| ds_req | input | 1 | Deep-sleep active |
| pad_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output value |
| pin_oe | output | 8 | Pad output driver enable |
| pin_ana | output | 8 | Analog connect control |
| pin_ibe | output | 8 | Pad input buffer enable |

## Verification
The routing is combinational, so a change on a source or pad input shows on the pin outputs in the same cycle. The bench changes those inputs just after a falling edge and compares the outputs one time unit later. A register write, a deep-sleep capture and a release each take effect at the next rising edge. The reference model applies those updates at that edge, so a result is first compared in the cycle after it. A write offered during deep sleep must leave `rd_data` unchanged in that following cycle.

// File: rtl/pin_route_pkg.sv
package pin_route_pkg;
   localparam int unsigned CODE_W     = 4;
   localparam int unsigned ACT_SRCS   = 4;
   localparam int unsigned DS_SRCS    = 2;
   localparam logic [3:0]  C_FW_GPIO  = 4'd0;
   localparam logic [3:0]  C_ANA_LO   = 4'd4;
   localparam logic [3:0]  C_ANA_HI   = 4'd7;
   localparam logic [3:0]  C_ACT_BASE = 4'd8;
   localparam logic [3:0]  C_DS_BASE  = 4'd14;
   localparam logic [3:0]  C_DEBUG    = 4'd15;

   typedef struct packed {
      logic drv;
      logic en;
      logic ana;
      logic ibe;
      logic dsrc;
   } lane_ctl_t;
endpackage

// File: rtl/pin_route_cfg.sv
module pin_route_cfg
   import pin_route_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8,
   parameter logic [NUM_PINS-1:0] DBG_PINS = '0,
   localparam int unsigned REG_W = NUM_PINS * CODE_W,
   localparam int unsigned NB    = REG_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [NB-1:0]    wr_be,
   input  logic [REG_W-1:0] wr_data,
   input  logic             lock,
   output logic [REG_W-1:0] sel_q,
   output logic [NUM_PINS-1:0] cfg_ok
);
   localparam int unsigned PINS_PER_BYTE = 8 / CODE_W;

   function automatic logic [REG_W-1:0] reset_sel();
      logic [REG_W-1:0] v;
      v = '0;
      for (int p = 0; p < NUM_PINS; p++)
         if (DBG_PINS[p]) v[p*CODE_W +: CODE_W] = C_DEBUG;
      return v;
   endfunction

   localparam logic [REG_W-1:0] SEL_RST = reset_sel();

   logic [NB-1:0] lane_wr;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign lane_wr[b] = wr_en && !lock && wr_be[b];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_q[b*8 +: 8] <= SEL_RST[b*8 +: 8];
         else if (lane_wr[b])
            sel_q[b*8 +: 8] <= wr_data[b*8 +: 8];
      end

      for (genvar k = 0; k < PINS_PER_BYTE; k++) begin : g_pin
         localparam int unsigned P = b * PINS_PER_BYTE + k;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg_ok[P] <= DBG_PINS[P];
            else if (lane_wr[b])
               cfg_ok[P] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pin_route_lane.sv
module pin_route_lane
   import pin_route_pkg::*;
(
   input  logic [CODE_W-1:0]   code,
   input  logic                cfg_ok,
   input  logic                fw_out,
   input  logic                fw_oe,
   input  logic [ACT_SRCS-1:0] act_o,
   input  logic [ACT_SRCS-1:0] act_e,
   input  logic [DS_SRCS-1:0]  ds_o,
   input  logic [DS_SRCS-1:0]  ds_e,
   input  logic                pad,
   output lane_ctl_t           ctl,
   output logic                fw_in,
   output logic [ACT_SRCS-1:0] act_i,
   output logic [DS_SRCS-1:0]  ds_i
);
   always_comb begin
      ctl      = '0;
      ctl.ibe  = cfg_ok;
      if (!cfg_ok) begin
         ctl.ana = 1'b1;
      end else if (code == C_FW_GPIO) begin
         ctl.drv = fw_out;
         ctl.en  = fw_oe;
      end else if (code >= C_ANA_LO && code <= C_ANA_HI) begin
         ctl.ana = 1'b1;
      end else if (code >= C_ACT_BASE && code < C_ACT_BASE + 4'(ACT_SRCS)) begin
         ctl.drv = act_o[code[1:0]];
         ctl.en  = act_e[code[1:0]];
      end else if (code >= C_DS_BASE) begin
         ctl.drv  = ds_o[code[0]];
         ctl.en   = ds_e[code[0]];
         ctl.dsrc = 1'b1;
      end
   end

   assign fw_in = pad & cfg_ok;

   for (genvar k = 0; k < ACT_SRCS; k++) begin : g_act
      assign act_i[k] = pad & cfg_ok & (code == C_ACT_BASE + 4'(k));
   end
   for (genvar k = 0; k < DS_SRCS; k++) begin : g_ds
      assign ds_i[k] = pad & cfg_ok & (code == C_DS_BASE + 4'(k));
   end
endmodule

// File: rtl/pin_route_hold.sv
module pin_route_hold #(
   parameter int unsigned NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ds_req,
   input  logic [NUM_PINS-1:0] live_out,
   input  logic [NUM_PINS-1:0] live_oe,
   input  logic [NUM_PINS-1:0] awake_src,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);
   logic                frozen;
   logic [NUM_PINS-1:0] held_out, held_oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frozen   <= 1'b0;
         held_out <= '0;
         held_oe  <= '0;
      end else if (ds_req) begin
         if (!frozen) begin
            frozen   <= 1'b1;
            held_out <= live_out;
            held_oe  <= live_oe;
         end
      end else begin
         frozen <= 1'b0;
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pin_out[p] = (frozen && !awake_src[p]) ? held_out[p] : live_out[p];
      assign pin_oe[p]  = (frozen && !awake_src[p]) ? held_oe[p]  : live_oe[p];
   end
endmodule

// File: rtl/pin_route_mux.sv
module pin_route_mux
   import pin_route_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8,
   parameter logic [NUM_PINS-1:0] DBG_PINS = 8'b1100_0000,
   localparam int unsigned REG_W = NUM_PINS * CODE_W,
   localparam int unsigned NB    = REG_W / 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [NB-1:0]                wr_be,
   input  logic [REG_W-1:0]             wr_data,
   output logic [REG_W-1:0]             rd_data,
   input  logic [NUM_PINS-1:0]          gpio_dout,
   input  logic [NUM_PINS-1:0]          gpio_doe,
   output logic [NUM_PINS-1:0]          gpio_din,
   input  logic [NUM_PINS*ACT_SRCS-1:0] act_out,
   input  logic [NUM_PINS*ACT_SRCS-1:0] act_oe,
   output logic [NUM_PINS*ACT_SRCS-1:0] act_in,
   input  logic [NUM_PINS*DS_SRCS-1:0]  ds_out,
   input  logic [NUM_PINS*DS_SRCS-1:0]  ds_oe,
   output logic [NUM_PINS*DS_SRCS-1:0]  ds_in,
   input  logic                         ds_req,
   input  logic [NUM_PINS-1:0]          pad_in,
   output logic [NUM_PINS-1:0]          pin_out,
   output logic [NUM_PINS-1:0]          pin_oe,
   output logic [NUM_PINS-1:0]          pin_ana,
   output logic [NUM_PINS-1:0]          pin_ibe
);
   if (CODE_W != 4) begin : g_bad_code
      $error("pin_route_mux: select field must be 4 bits");
   end
   if (NUM_PINS % 2 != 0 || NUM_PINS < 2) begin : g_bad_pins
      $error("pin_route_mux: pin count must be even and at least 2");
   end

   logic [NUM_PINS-1:0] cfg_ok, live_out, live_oe, awake_src;

   pin_route_cfg #(.NUM_PINS(NUM_PINS), .DBG_PINS(DBG_PINS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
      .wr_data(wr_data), .lock(ds_req), .sel_q(rd_data), .cfg_ok(cfg_ok)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
      lane_ctl_t ctl;
      pin_route_lane u_lane (
         .code  (rd_data[p*CODE_W +: CODE_W]),
         .cfg_ok(cfg_ok[p]),
         .fw_out(gpio_dout[p]),
         .fw_oe (gpio_doe[p]),
         .act_o (act_out[p*ACT_SRCS +: ACT_SRCS]),
         .act_e (act_oe[p*ACT_SRCS +: ACT_SRCS]),
         .ds_o  (ds_out[p*DS_SRCS +: DS_SRCS]),
         .ds_e  (ds_oe[p*DS_SRCS +: DS_SRCS]),
         .pad   (pad_in[p]),
         .ctl   (ctl),
         .fw_in (gpio_din[p]),
         .act_i (act_in[p*ACT_SRCS +: ACT_SRCS]),
         .ds_i  (ds_in[p*DS_SRCS +: DS_SRCS])
      );
      assign live_out[p]  = ctl.drv;
      assign live_oe[p]   = ctl.en;
      assign pin_ana[p]   = ctl.ana;
      assign pin_ibe[p]   = ctl.ibe;
      assign awake_src[p] = ctl.dsrc;
   end

   pin_route_hold #(.NUM_PINS(NUM_PINS)) u_hold (
      .clk(clk), .rst_n(rst_n), .ds_req(ds_req),
      .live_out(live_out), .live_oe(live_oe), .awake_src(awake_src),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );
endmodule

// File: rtl/pin_route_chk.sv
module pin_route_chk #(
   parameter int unsigned NUM_PINS = 8,
   localparam int unsigned REG_W = NUM_PINS * 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ds_req,
   input logic [REG_W-1:0]      rd_data,
   input logic [NUM_PINS*2-1:0] ds_out,
   input logic [NUM_PINS*2-1:0] ds_oe,
   input logic [NUM_PINS-1:0]   pin_out,
   input logic [NUM_PINS-1:0]   pin_oe,
   input logic [NUM_PINS-1:0]   pin_ana,
   input logic [NUM_PINS-1:0]   pin_ibe
);
   p_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ds_req |=> $stable(rd_data));

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [3:0] c;
      assign c = rd_data[p*4 +: 4];

      p_analog_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (pin_ibe[p] && c >= 4'd4 && c <= 4'd7) |-> (pin_ana[p] && !pin_oe[p]));

      p_dsrc_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (pin_ibe[p] && c >= 4'd14) |->
         (pin_out[p] == ds_out[2*p + int'(c[0])] && pin_oe[p] == ds_oe[2*p + int'(c[0])]));

      p_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (pin_ibe[p] && (c inside {4'd1, 4'd2, 4'd3, 4'd12, 4'd13})) |->
         (!pin_oe[p] && !pin_ana[p]));

      p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(ds_req) && ds_req && c < 4'd14) |->
         ($stable(pin_out[p]) && $stable(pin_oe[p])));

      p_ibe_r11: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && ds_req && $past(pin_ibe[p])) |-> pin_ibe[p]);
   end
endmodule

bind pin_route_mux pin_route_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .ds_req(ds_req), .rd_data(rd_data),
   .ds_out(ds_out), .ds_oe(ds_oe), .pin_out(pin_out), .pin_oe(pin_oe),
   .pin_ana(pin_ana), .pin_ibe(pin_ibe)
);

// File: tb/pin_route_mux_test.sv
module pin_route_mux_test;
   localparam int NP = 8;
   localparam logic [NP-1:0] DBG = 8'b1100_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [3:0] wr_be = '0;
   logic [31:0] wr_data = '0, rd_data;
   logic [7:0] gpio_dout = '0, gpio_doe = '0, gpio_din;
   logic [31:0] act_out = '0, act_oe = '0, act_in;
   logic [15:0] ds_out = '0, ds_oe = '0, ds_in;
   logic ds_req = 1'b0;
   logic [7:0] pad_in = '0, pin_out, pin_oe, pin_ana, pin_ibe;

   always #10 clk = ~clk;

   pin_route_mux #(.NUM_PINS(NP), .DBG_PINS(DBG)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
      .rd_data(rd_data), .gpio_dout(gpio_dout), .gpio_doe(gpio_doe),
      .gpio_din(gpio_din), .act_out(act_out), .act_oe(act_oe), .act_in(act_in),
      .ds_out(ds_out), .ds_oe(ds_oe), .ds_in(ds_in), .ds_req(ds_req),
      .pad_in(pad_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_ana(pin_ana),
      .pin_ibe(pin_ibe)
   );

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   logic [31:0] m_sel;
   logic [7:0]  m_ok, m_hout, m_hoe;
   logic        m_frz;
   bit          prev_lock;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] code_of(int p);
      return m_sel[p*4 +: 4];
   endfunction

   // live expectation: {out, oe, ana, ibe}
   function automatic logic [3:0] live(int p);
      logic [3:0] c;
      c = code_of(p);
      if (!m_ok[p]) return 4'b0010;
      if (c == 0) return {gpio_dout[p], gpio_doe[p], 2'b01};
      if (c >= 4 && c <= 7) return 4'b0011;
      if (c >= 8 && c <= 11) return {act_out[p*4 + int'(c - 8)], act_oe[p*4 + int'(c - 8)], 2'b01};
      if (c >= 14) return {ds_out[p*2 + int'(c - 14)], ds_oe[p*2 + int'(c - 14)], 2'b01};
      return 4'b0001;
   endfunction

   function automatic string tag_of(int p);
      logic [3:0] c;
      c = code_of(p);
      if (!m_ok[p]) return "R2";
      if (m_frz && c < 14) return "R9";
      if (c == 0) return "R3";
      if (c >= 4 && c <= 7) return "R4";
      if (c >= 8 && c <= 11) return "R5";
      if (c >= 14) return "R6";
      return "R7";
   endfunction

   task automatic check_all();
      chk(prev_lock ? "R10" : "R1", rd_data, m_sel);
      for (int p = 0; p < NP; p++) begin
         logic [3:0] e;
         logic [3:0] c;
         logic [3:0] ea;
         logic [1:0] ed;
         e = live(p);
         c = code_of(p);
         if (m_frz && c < 14) begin
            e[3] = m_hout[p];
            e[2] = m_hoe[p];
         end
         chk(tag_of(p), {30'b0, pin_out[p], pin_oe[p]}, {30'b0, e[3], e[2]});
         chk(tag_of(p), {31'b0, pin_ana[p]}, {31'b0, e[1]});
         chk(ds_req ? "R11" : tag_of(p), {31'b0, pin_ibe[p]}, {31'b0, e[0]});
         ea = '0;
         ed = '0;
         if (m_ok[p] && c >= 8 && c <= 11) ea[c - 8] = pad_in[p];
         if (m_ok[p] && c >= 14) ed[c - 14] = pad_in[p];
         chk("R8", {31'b0, gpio_din[p]}, {31'b0, pad_in[p] & m_ok[p]});
         chk("R8", {28'b0, act_in[p*4 +: 4]}, {28'b0, ea});
         chk("R8", {30'b0, ds_in[p*2 +: 2]}, {30'b0, ed});
      end
   endtask

   task automatic model_edge();
      prev_lock = ds_req && wr_en;
      if (ds_req) begin
         if (!m_frz) begin
            for (int p = 0; p < NP; p++) begin
               logic [3:0] e;
               e = live(p);
               m_hout[p] = e[3];
               m_hoe[p]  = e[2];
            end
            m_frz = 1'b1;
         end
      end else begin
         m_frz = 1'b0;
         if (wr_en)
            for (int b = 0; b < 4; b++)
               if (wr_be[b]) begin
                  m_sel[b*8 +: 8] = wr_data[b*8 +: 8];
                  m_ok[2*b] = 1'b1;
                  m_ok[2*b+1] = 1'b1;
               end
      end
   endtask

   task automatic rand_src();
      gpio_dout = 8'($urandom);
      gpio_doe  = 8'($urandom);
      act_out   = $urandom;
      act_oe    = $urandom;
      ds_out    = 16'($urandom);
      ds_oe     = 16'($urandom);
      pad_in    = 8'($urandom);
   endtask

   task automatic cycle(logic we, logic [3:0] be, logic [31:0] d, logic dsr);
      @(negedge clk);
      wr_en = we; wr_be = be; wr_data = d; ds_req = dsr;
      rand_src();
      #1 check_all();
      @(posedge clk);
      model_edge();
   endtask

   initial begin
      #4_000_000;
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic dsr;
      void'($urandom(32'h5eed_1234));
      m_sel = 32'hFF00_0000; m_ok = DBG; m_frz = 0; m_hout = 0; m_hoe = 0;
      prev_lock = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R2 reset state, checked with random sources
      cycle(0, 0, 0, 0);
      cycle(0, 0, 0, 0);
      // R1 partial write: pins 0,1 to codes 4 and 9; pins 2..5 stay unconfigured (R2)
      cycle(1, 4'b0001, 32'hAAAA_AA94, 0);
      cycle(0, 0, 0, 0);
      // all codes across the port, including unused ones (R7)
      cycle(1, 4'b1111, 32'hF1C5_A803, 0);
      cycle(0, 0, 0, 0);
      cycle(1, 4'b1111, 32'hE2D6_B70D, 0);
      cycle(0, 0, 0, 0);
      // R9 freeze with R10 write attempt during it
      cycle(0, 0, 0, 1);
      cycle(1, 4'b1111, 32'h0000_0000, 1);
      repeat (4) cycle(0, 0, 0, 1);
      cycle(0, 0, 0, 0);
      cycle(0, 0, 0, 0);
      // random phase
      dsr = 0;
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] d;
         if ($urandom_range(0, 19) == 0) dsr = ~dsr;
         d = $urandom;
         cycle(($urandom_range(0, 2) == 0), 4'($urandom), d, dsr);
      end
      cycle(0, 0, 0, 0);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule